// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture

A 32-bit timer peripheral reached through a plain register port (write strobe, address, write data, combinational read data). In timer mode a prescale counter counts bus clocks up to a programmable limit, and the main counter advances once each time that limit is passed. In counter mode the prescaler stands still and the main counter advances on chosen edges of one of the two external inputs. Those inputs pass through a two-stage synchronizer before any edge is detected.

Four match channels compare their values against the main counter on every count step. A hit can raise a pending flag, return the main counter to zero, and drive a match output with a programmable action. As an alternative, a match output can run as a PWM output that rises on its own match and falls when the counter is reset by a match. Two capture channels copy the main counter on selected input edges. All events collect in one pending register that software clears by writing ones, and the interrupt output is high while any flag is pending.

Top module: `prescaled_timer`

## Requirements
- R1: In timer mode (count-mode field 0) with run set (control bit 0), each clock in which the prescale counter equals the limit register resets the prescale counter to 0 and steps the main counter. Otherwise the prescale counter increments, so the main counter advances once every limit+1 clocks.
- R2: With run clear, neither counter moves. While control bit 1 is set, both counters are held at 0 whatever run is.
- R3: The register offsets are: pending 0x00, control 0x04, main counter 0x08, limit 0x0C, prescale counter 0x10, match control 0x14, match values 0x18/0x1C/0x20/0x24, capture control 0x28, capture values 0x2C/0x30, output control 0x3C, count mode 0x70, PWM enable 0x74. Unmapped offsets read 0. A bus write to a counter takes priority over counting.
- R4: Match i is hit on a count step when the main counter equals match value i. Match control bit 2i enables its pending flag. Bit 2i+1 makes that step load 0 into the main counter instead of counter+1.
- R5: Pending bit i (0 to 3) flags match i and bit 4+j flags capture j. Bits 6 and 7 always read 0. Writing a 1 to a bit clears it, and writing a 0 leaves it. irq_o is high while any bit is set.
- R6: Output control bits [3:0] hold the match outputs and can be written directly. Bits [5+2i:4+2i] select what a hit of match i does to output i: 0 none, 1 clear, 2 set, 3 toggle.
- R7: With PWM enable bit i set, output i goes high on a hit of match i and low on any step in which a match resets the counter. The low wins if both happen in the same step.
- R8: Count-mode bits [1:0] = 1, 2 or 3 select counter mode on rising, falling or both edges of cap_i[bit 2]. The prescale counter then keeps its value.
- R9: Capture control bit 3j loads capture j with the main counter on a rising edge of cap_i[j], and bit 3j+1 does the same on a falling edge. Bit 3j+2 enables its pending flag. An edge that is not enabled leaves capture j unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| cap_i | input | 2 | External inputs for capture and counter mode |
| mat_o | output | 4 | Match outputs |
| irq_o | output | 1 | High while any pending flag is set |

## Verification
The assertions assume that an output-control write does not coincide with a counter-reset match. They also assume that cap_i levels are held long enough for the two-stage synchronizer to see each edge. The stimulus holds every input level for four clocks and changes output control only while the counter is stopped. Count sequences are checked by stopping the counter and reading it back, so the exact synchronizer latency never enters an expected value. Captures are likewise taken with the counter stopped, so each expected captured value is the value last written.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W        = 8;
  localparam int PEND_W        = 8;
  localparam int CAP_PEND_BASE = 4;
  localparam int EMAT_ACT_BASE = 4;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_LIM   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PCNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MCTL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MVAL0 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CCTL  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CAP0  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_EMAT  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_CMODE = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_PWM   = 8'h74;

  typedef enum logic [1:0] {ACT_NONE, ACT_CLR, ACT_SET, ACT_TGL} mat_act_e;
  typedef enum logic [1:0] {CM_TIMER, CM_RISE, CM_FALL, CM_BOTH} cnt_mode_e;
endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= din_i[k];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[k] = s2_q & ~s3_q;
    assign fall_o[k] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic         bypass_i,
  input  logic [W-1:0] lim_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pcnt_o,
  output logic         tick_o
);
  logic [W-1:0] pcnt_q;

  assign tick_o = run_i && !hold_i && !bypass_i && (pcnt_q == lim_i);
  assign pcnt_o = pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (hold_i)            pcnt_q <= '0;
    else if (wr_i)              pcnt_q <= wdata_i;
    else if (run_i && !bypass_i) pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_match.sv
module ptmr_match
  import ptmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] mval_i,
  input  mat_act_e     act_i,
  input  logic         pwm_i,
  input  logic         rst_evt_i,
  input  logic         out_wr_i,
  input  logic         out_wdata_i,
  output logic         hit_o,
  output logic         out_o
);
  logic out_q;

  assign hit_o = step_i && (cnt_i == mval_i);
  assign out_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else if (out_wr_i) out_q <= out_wdata_i;
    else if (pwm_i) begin
      // counter reset dominates own match
      if (rst_evt_i)  out_q <= 1'b0;
      else if (hit_o) out_q <= 1'b1;
    end else if (hit_o) begin
      unique case (act_i)
        ACT_CLR: out_q <= 1'b0;
        ACT_SET: out_q <= 1'b1;
        ACT_TGL: out_q <= ~out_q;
        default: out_q <= out_q;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_capture.sv
module ptmr_capture #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         en_rise_i,
  input  logic         en_fall_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         evt_o
);
  logic [W-1:0] cap_q;

  assign evt_o = (rise_i && en_rise_i) || (fall_i && en_fall_i);
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (evt_o) cap_q <= cnt_i;
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]     rdata_o,
  input  logic [NUM_CAP-1:0]   cap_i,
  output logic [NUM_MATCH-1:0] mat_o,
  output logic                 irq_o
);
  localparam int MCTL_W = 2 * NUM_MATCH;
  localparam int CCTL_W = 3 * NUM_CAP;
  localparam int ACT_W  = 2 * NUM_MATCH;

  logic [1:0]          ctrl_q;
  logic [CNT_W-1:0]    cnt_q, lim_q;
  logic [MCTL_W-1:0]   mctl_q;
  logic [CCTL_W-1:0]   cctl_q;
  logic [ACT_W-1:0]    act_q;
  logic [2:0]          cmode_q;
  logic [NUM_MATCH-1:0] pwmen_q;
  logic [PEND_W-1:0]   pend_q, pend_set;
  logic [CNT_W-1:0]    mval_q [NUM_MATCH];

  logic cnt_wr, pcnt_wr, pend_wr, emat_wr;
  assign cnt_wr  = we_i && (addr_i == OFS_CNT);
  assign pcnt_wr = we_i && (addr_i == OFS_PCNT);
  assign pend_wr = we_i && (addr_i == OFS_PEND);
  assign emat_wr = we_i && (addr_i == OFS_EMAT);

  logic run, hold, timer_mode;
  cnt_mode_e mode;
  assign run        = ctrl_q[0];
  assign hold       = ctrl_q[1];
  assign mode       = cnt_mode_e'(cmode_q[1:0]);
  assign timer_mode = (mode == CM_TIMER);

  // input synchronizer and edge detect
  logic [NUM_CAP-1:0] rise, fall;
  ptmr_sync_edge #(.N(NUM_CAP)) u_sync (
    .clk_i, .rst_ni, .din_i(cap_i), .rise_o(rise), .fall_o(fall)
  );

  logic cnt_edge;
  always_comb begin
    unique case (mode)
      CM_RISE: cnt_edge = rise[cmode_q[2]];
      CM_FALL: cnt_edge = fall[cmode_q[2]];
      CM_BOTH: cnt_edge = rise[cmode_q[2]] | fall[cmode_q[2]];
      default: cnt_edge = 1'b0;
    endcase
  end

  logic [CNT_W-1:0] pcnt;
  logic tick, step;
  ptmr_prescale #(.W(CNT_W)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .hold_i(hold), .bypass_i(!timer_mode),
    .lim_i(lim_q), .wr_i(pcnt_wr), .wdata_i, .pcnt_o(pcnt), .tick_o(tick)
  );

  assign step = run && !hold && (timer_mode ? tick : cnt_edge);

  // match channels
  logic [NUM_MATCH-1:0] hit, irq_en, rst_en;
  logic rst_evt;
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    assign irq_en[i] = mctl_q[2*i];
    assign rst_en[i] = mctl_q[2*i+1];
    ptmr_match #(.W(CNT_W)) u_match (
      .clk_i, .rst_ni, .step_i(step), .cnt_i(cnt_q), .mval_i(mval_q[i]),
      .act_i(mat_act_e'(act_q[2*i +: 2])), .pwm_i(pwmen_q[i]),
      .rst_evt_i(rst_evt), .out_wr_i(emat_wr), .out_wdata_i(wdata_i[i]),
      .hit_o(hit[i]), .out_o(mat_o[i])
    );
  end
  assign rst_evt = |(hit & rst_en);

  // capture channels
  logic [NUM_CAP-1:0] cap_evt, cap_irq;
  logic [CNT_W-1:0]   cap_val [NUM_CAP];
  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    assign cap_irq[j] = cctl_q[3*j+2];
    ptmr_capture #(.W(CNT_W)) u_cap (
      .clk_i, .rst_ni, .rise_i(rise[j]), .fall_i(fall[j]),
      .en_rise_i(cctl_q[3*j]), .en_fall_i(cctl_q[3*j+1]),
      .cnt_i(cnt_q), .cap_o(cap_val[j]), .evt_o(cap_evt[j])
    );
  end

  always_comb begin
    pend_set = '0;
    pend_set[NUM_MATCH-1:0] = hit & irq_en;
    pend_set[CAP_PEND_BASE +: NUM_CAP] = cap_evt & cap_irq;
  end

  // main counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold)   cnt_q <= '0;
    else if (cnt_wr) cnt_q <= wdata_i;
    else if (step)   cnt_q <= rst_evt ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= (pend_q & ~(pend_wr ? wdata_i[PEND_W-1:0] : '0)) | pend_set;
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      lim_q   <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      act_q   <= '0;
      cmode_q <= '0;
      pwmen_q <= '0;
      for (int i = 0; i < NUM_MATCH; i++) mval_q[i] <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_CTRL:  ctrl_q  <= wdata_i[1:0];
        OFS_LIM:   lim_q   <= wdata_i;
        OFS_MCTL:  mctl_q  <= wdata_i[MCTL_W-1:0];
        OFS_CCTL:  cctl_q  <= wdata_i[CCTL_W-1:0];
        OFS_EMAT:  act_q   <= wdata_i[EMAT_ACT_BASE +: ACT_W];
        OFS_CMODE: cmode_q <= wdata_i[2:0];
        OFS_PWM:   pwmen_q <= wdata_i[NUM_MATCH-1:0];
        default: ;
      endcase
      for (int i = 0; i < NUM_MATCH; i++)
        if (addr_i == OFS_MVAL0 + 8'(4*i)) mval_q[i] <= wdata_i;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_PEND:  rdata_o = CNT_W'(pend_q);
      OFS_CTRL:  rdata_o = CNT_W'(ctrl_q);
      OFS_CNT:   rdata_o = cnt_q;
      OFS_LIM:   rdata_o = lim_q;
      OFS_PCNT:  rdata_o = pcnt;
      OFS_MCTL:  rdata_o = CNT_W'(mctl_q);
      OFS_CCTL:  rdata_o = CNT_W'(cctl_q);
      OFS_EMAT: begin
        rdata_o[NUM_MATCH-1:0]             = mat_o;
        rdata_o[EMAT_ACT_BASE +: ACT_W]    = act_q;
      end
      OFS_CMODE: rdata_o = CNT_W'(cmode_q);
      OFS_PWM:   rdata_o = CNT_W'(pwmen_q);
      default: ;
    endcase
    for (int i = 0; i < NUM_MATCH; i++)
      if (addr_i == OFS_MVAL0 + 8'(4*i)) rdata_o = mval_q[i];
    for (int j = 0; j < NUM_CAP; j++)
      if (addr_i == OFS_CAP0 + 8'(4*j)) rdata_o = cap_val[j];
  end

  assign irq_o = |pend_q;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
  import ptmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 run_i,
  input logic                 hold_i,
  input logic                 timer_mode_i,
  input logic                 pcnt_wr_i,
  input logic                 cnt_wr_i,
  input logic                 step_i,
  input logic                 rst_evt_i,
  input logic                 emat_wr_i,
  input logic [CNT_W-1:0]     pcnt_i,
  input logic [CNT_W-1:0]     lim_i,
  input logic [CNT_W-1:0]     cnt_i,
  input logic [PEND_W-1:0]    pend_i,
  input logic                 pend_wr_i,
  input logic [NUM_MATCH-1:0] pwmen_i,
  input logic [NUM_MATCH-1:0] mat_i
);
  // R1
  presc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hold_i && timer_mode_i && !pcnt_wr_i && (pcnt_i != lim_i))
      |=> (pcnt_i == $past(pcnt_i) + 1'b1));

  // R1
  cnt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(hold_i) && !$past(cnt_wr_i) && !$past(step_i)) |-> $stable(cnt_i));

  // R2
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ((cnt_i == '0) && (pcnt_i == '0)));

  // R5
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pend_wr_i) |-> (($past(pend_i) & ~pend_i) == '0));

  // R5
  pend_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i[7:6] == 2'b00);

  // R7
  pwm_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_evt_i) && !$past(emat_wr_i)) |-> ((mat_i & $past(pwmen_i)) == '0));
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .hold_i(hold),
  .timer_mode_i(timer_mode), .pcnt_wr_i(pcnt_wr), .cnt_wr_i(cnt_wr),
  .step_i(step), .rst_evt_i(rst_evt), .emat_wr_i(emat_wr),
  .pcnt_i(pcnt), .lim_i(lim_q), .cnt_i(cnt_q), .pend_i(pend_q),
  .pend_wr_i(pend_wr), .pwmen_i(pwmen_q), .mat_i(mat_o)
);

// File: tb/prescaled_timer_tb_top.sv
module prescaled_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [7:0] A_PEND = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08, A_LIM = 8'h0C,
                         A_PCNT = 8'h10, A_MCTL = 8'h14, A_M0 = 8'h18, A_M1 = 8'h1C,
                         A_M2 = 8'h20, A_M3 = 8'h24, A_CCTL = 8'h28, A_C0 = 8'h2C,
                         A_C1 = 8'h30, A_EMAT = 8'h3C, A_CMODE = 8'h70, A_PWM = 8'h74;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  cap = '0;
  logic [3:0]  mat;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .mat_o(mat), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic clr_cnt();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
  endtask

  // k+1 counted clocks
  task automatic run_for(int k);
    wr(A_CTRL, 32'h1);
    repeat (k) @(negedge clk);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic pulse(int idx);
    cap[idx] = 1'b1;
    repeat (4) @(negedge clk);
    cap[idx] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v);  chk("R2 reset cnt", v, 0);
    rd(A_PEND, v); chk("R5 reset pend", v, 0);
    chk("R6 reset mat_o", 32'(mat), 0);
    chk("R5 reset irq_o", 32'(irq), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_CNT, 32'hDEADBEEF); rd(A_CNT, v); chk("R3 cnt rw", v, 32'hDEADBEEF);
    wr(A_PCNT, 32'h5);       rd(A_PCNT, v); chk("R3 pcnt rw", v, 32'h5);
    wr(A_LIM, 32'h3);        rd(A_LIM, v); chk("R3 lim rw", v, 32'h3);
    wr(A_M2, 32'hA5A5);      rd(A_M2, v);  chk("R3 match2 rw", v, 32'hA5A5);
    rd(8'h40, v);            chk("R3 unmapped", v, 0);
    clr_cnt();
    wr(A_PCNT, 32'h3);
    run_for(0);
    rd(A_CNT, v);  chk("R3 pcnt write reaches limit", v, 1);
    rd(A_PCNT, v); chk("R3 pcnt wrapped", v, 0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    clr_cnt();
    wr(A_LIM, 32'h2);
    run_for(9);
    rd(A_CNT, v);  chk("R1 cnt lim2", v, 3);
    rd(A_PCNT, v); chk("R1 pcnt lim2", v, 1);
    clr_cnt();
    wr(A_LIM, 32'h0);
    run_for(4);
    rd(A_CNT, v);  chk("R1 cnt lim0", v, 5);
    rd(A_PCNT, v); chk("R1 pcnt lim0", v, 0);
  endtask

  task automatic t_stop_hold();
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R2 stopped cnt", v, 5);
    wr(A_CTRL, 32'h3);
    repeat (4) @(negedge clk);
    rd(A_CNT, v);  chk("R2 hold cnt", v, 0);
    rd(A_PCNT, v); chk("R2 hold pcnt", v, 0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    clr_cnt();
    wr(A_LIM, 32'h0);
    wr(A_M0, 32'd4); wr(A_M1, 32'd2); wr(A_M2, 32'd3); wr(A_M3, 32'd1);
    wr(A_MCTL, 32'h3);
    // out3=1, ch1 toggle, ch2 set, ch3 clear
    wr(A_EMAT, 32'h6C8);
    run_for(6);
    rd(A_CNT, v);  chk("R4 match reset period", v, 2);
    rd(A_PEND, v); chk("R4 pend only enabled match", v, 32'h01);
    chk("R5 irq_o set", 32'(irq), 1);
    chk("R6 output actions", 32'(mat), 32'h6);
    rd(A_EMAT, v); chk("R6 emat readback", v, 32'h6C6);
    wr(A_PEND, 32'hC0);
    rd(A_PEND, v); chk("R5 write 0 keeps flag", v, 32'h01);
    wr(A_PEND, 32'h01);
    rd(A_PEND, v); chk("R5 write 1 clears", v, 0);
    chk("R5 irq_o clear", 32'(irq), 0);
  endtask

  task automatic t_pwm();
    logic [31:0] v;
    clr_cnt();
    wr(A_EMAT, 32'h0);
    wr(A_PWM, 32'h2);
    run_for(2);
    chk("R7 pwm high after match", 32'(mat), 32'h2);
    rd(A_CNT, v); chk("R7 cnt mid", v, 3);
    run_for(1);
    chk("R7 pwm low after reset", 32'(mat), 0);
    rd(A_CNT, v); chk("R7 cnt wrapped", v, 0);
    wr(A_PWM, 32'h0);
    wr(A_PEND, 32'hFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_MCTL, 0); wr(A_CCTL, 0); wr(A_EMAT, 0);
    clr_cnt();
    wr(A_LIM, 32'h5);
    wr(A_CMODE, 32'h1);
    wr(A_CTRL, 32'h1);
    pulse(0); pulse(0); pulse(1); pulse(0);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v);  chk("R8 rising input0", v, 3);
    rd(A_PCNT, v); chk("R8 prescaler held", v, 0);
    clr_cnt();
    wr(A_CMODE, 32'h7);
    wr(A_CTRL, 32'h1);
    pulse(1); pulse(1);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v); chk("R8 both edges input1", v, 4);
    clr_cnt();
    wr(A_CMODE, 32'h2);
    wr(A_CTRL, 32'h1);
    pulse(0); pulse(0);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v); chk("R8 falling input0", v, 2);
    wr(A_CMODE, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(A_CCTL, 32'h35);
    wr(A_CNT, 32'h1234);
    cap[0] = 1'b1; repeat (5) @(negedge clk);
    rd(A_C0, v);   chk("R9 rise capture0", v, 32'h1234);
    rd(A_PEND, v); chk("R9 capture0 pend", v, 32'h10);
    cap[1] = 1'b1; repeat (5) @(negedge clk);
    rd(A_C1, v);   chk("R9 rise ignored capture1", v, 0);
    wr(A_CNT, 32'h55);
    cap[1] = 1'b0; repeat (5) @(negedge clk);
    rd(A_C1, v);   chk("R9 fall capture1", v, 32'h55);
    rd(A_PEND, v); chk("R9 both capture pend", v, 32'h30);
    cap[0] = 1'b0; repeat (5) @(negedge clk);
    rd(A_C0, v);   chk("R9 fall ignored capture0", v, 32'h1234);
    wr(A_PEND, 32'h30);
    chk("R5 irq_o after capture clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_timer();
    t_stop_hold();
    t_match();
    t_pwm();
    t_count();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule